// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is a byte-addressed non-volatile-memory model that answers as a slave on a two-wire serial bus. The bus clock arrives on `scl_i`. The shared data line is split into a sampled input `sda_i` and a pull-low enable `sda_oe_o`, which the pad ring turns into an open-drain driver. Both bus inputs are sampled in the system clock domain. Start and stop conditions, SCL edges and the byte and acknowledge slots are all derived from those samples.

The storage is a register array inside the block, made of `2**BLK_BITS` blocks of 256 bytes. A 7-bit device address selects the block. Its upper nibble is fixed at `1010`. Each of its three lower positions is either compared against a hardware address pin or used as a block-select bit, and the parameter `BLK_BITS` decides which. The block supports byte writes with an auto-incrementing pointer, current-address reads and sequential reads. A write-protect input prevents every memory update but leaves the bus protocol unchanged.

Top module: `serial_eeprom_slave`

## Requirements
- R1: A start condition (SDA falling while SCL is high) begins address reception from any state. A stop condition (SDA rising while SCL is high) returns the block to idle and releases SDA. Bytes clocked while idle are not acknowledged.
- R2: `sda_oe_o` changes only while SCL is low.
- R3: The address byte is sent MSB first as `1010 x2 x1 x0 rw`. Position xi (byte bit i+1) must equal `addr_pins_i[i]` when i >= `BLK_BITS`. Otherwise xi is a block-select bit and the pin is ignored. On a mismatch the block sends no acknowledge and drives nothing until the next start.
- R4: After a matching address, and after every byte received in a write, the block pulls SDA low for the whole ninth clock.
- R5: In a write (rw=0), the byte after the address sets the pointer to {block-select bits, byte}.
- R6: Each further write byte is stored at the pointer. The low 8 pointer bits then increment and wrap inside the current 256-byte block.
- R7: While `wp_i` is high, write bytes are still acknowledged and the pointer still advances, but memory is not changed.
- R8: In a read (rw=1), bytes go out MSB first, starting at the pointer. The pointer increments after each byte and wraps from the last array location to 0. When the master acknowledges, the next byte follows.
- R9: When the master does not acknowledge a read byte, the block releases SDA and drives nothing until the next start.
- R10: A read addressed without a preceding word address continues from the pointer left by the previous transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to sample the bus |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock from the master |
| sda_i | input | 1 | Sampled level of the shared data line |
| sda_oe_o | output | 1 | High pulls the data line low |
| addr_pins_i | input | 3 | Hardware address pins, bit i matched with address position xi |
| wp_i | input | 1 | High blocks all memory updates |

## Verification
The bench compares the design against its own model, which holds a memory image and a pointer. It runs several patterns. Byte writes followed by random reads show that the word address lands in the right block. A write that runs past byte 0xFF shows that writing wraps inside the block. A read started at the last location shows that reading wraps across the whole array. A current-address read after another transfer shows that the pointer is carried over. Protected writes must still be acknowledged while the memory image stays unchanged. Mismatched addresses, master not-acknowledge and traffic sent after a stop without a new start must all leave SDA released, which separates "ignored" from "accepted". A monitor checks every clock that the drive never changes while SCL is high.

// File: rtl/twi_ee_pkg.sv
package twi_ee_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DEV, ST_WORD, ST_WDATA, ST_ACK, ST_RDATA, ST_RACK
  } twi_st_e;

  // Address byte check: fixed nibble, pins only where not used as block bits.
  function automatic logic dev_match(input logic [7:0] b, input logic [2:0] pins,
                                     input int blk_bits);
    logic ok;
    ok = (b[7:4] == 4'b1010);
    for (int i = 0; i < 3; i++)
      if (i >= blk_bits && b[i+1] != pins[i]) ok = 1'b0;
    return ok;
  endfunction

  // Block-select bits taken from the address byte.
  function automatic logic [2:0] block_of(input logic [7:0] b, input int blk_bits);
    logic [2:0] blk;
    blk = '0;
    for (int i = 0; i < 3; i++)
      if (i < blk_bits) blk[i] = b[i+1];
    return blk;
  endfunction

  // Write pointer: low byte rolls over inside its block.
  function automatic logic [10:0] next_wr_ptr(input logic [10:0] p);
    return {p[10:8], p[7:0] + 8'd1};
  endfunction

  // Read pointer: rolls over at the top of the whole array.
  function automatic logic [10:0] next_rd_ptr(input logic [10:0] p, input int blk_bits);
    logic [10:0] lim;
    lim = (11'd256 << blk_bits) - 11'd1;
    return (p + 11'd1) & lim;
  endfunction

endpackage

// File: rtl/twi_line_mon.sv
module twi_line_mon (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_q_o,
  output logic sda_q_o,
  output logic start_o,
  output logic stop_o,
  output logic rise_o,
  output logic fall_o
);
  logic scl_q, sda_q, scl_p, sda_p;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1; sda_q <= 1'b1; scl_p <= 1'b1; sda_p <= 1'b1;
    end else begin
      scl_q <= scl_i; sda_q <= sda_i;
      scl_p <= scl_q; sda_p <= sda_q;
    end
  end

  assign scl_q_o = scl_q;
  assign sda_q_o = sda_q;
  assign start_o = scl_q & scl_p & sda_p & ~sda_q;
  assign stop_o  = scl_q & scl_p & ~sda_p & sda_q;
  assign rise_o  = scl_q & ~scl_p;
  assign fall_o  = ~scl_q & scl_p;

  p_events_onehot_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({start_o, stop_o, rise_o, fall_o}));
endmodule

// File: rtl/twi_ee_array.sv
module twi_ee_array #(
  parameter int AW = 9
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [7:0]    wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [7:0]    rdata_o
);
  localparam int DEPTH = 1 << AW;
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/twi_ee_ctrl.sv
module twi_ee_ctrl
  import twi_ee_pkg::*;
#(
  parameter int BLK_BITS = 1,
  parameter int AW       = 8 + BLK_BITS
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          scl_q_i,
  input  logic          sda_q_i,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic          rise_i,
  input  logic          fall_i,
  input  logic [2:0]    pins_i,
  input  logic          wp_i,
  input  logic [7:0]    rdata_i,
  output logic [AW-1:0] ptr_o,
  output logic          we_o,
  output logic [7:0]    wdata_o,
  output logic          sda_oe_o
);
  twi_st_e       st_q, after_q;
  logic [3:0]    cnt_q;
  logic [7:0]    sh_q;
  logic [2:0]    blk_q;
  logic [AW-1:0] ptr_q;
  logic          oe_q, mack_q;

  // named events for the assertions
  logic byte_done, addr_ok, wbyte_done;
  assign byte_done  = fall_i && (cnt_q == 4'd8);
  assign addr_ok    = dev_match(sh_q, pins_i, BLK_BITS);
  assign wbyte_done = byte_done && (st_q == ST_WDATA);

  assign we_o     = wbyte_done && !wp_i;
  assign wdata_o  = sh_q;
  assign ptr_o    = ptr_q;
  assign sda_oe_o = oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE; after_q <= ST_IDLE; cnt_q <= '0; sh_q <= '0;
      blk_q <= '0; ptr_q <= '0; oe_q <= 1'b0; mack_q <= 1'b0;
    end else if (start_i) begin
      st_q <= ST_DEV; cnt_q <= '0; oe_q <= 1'b0;
    end else if (stop_i) begin
      st_q <= ST_IDLE; oe_q <= 1'b0;
    end else if (rise_i) begin
      case (st_q)
        ST_DEV, ST_WORD, ST_WDATA: begin
          sh_q  <= {sh_q[6:0], sda_q_i};
          cnt_q <= cnt_q + 4'd1;
        end
        ST_RACK: begin
          mack_q <= !sda_q_i;
          ptr_q  <= AW'(next_rd_ptr(11'(ptr_q), BLK_BITS));
        end
        default: ;
      endcase
    end else if (fall_i) begin
      case (st_q)
        ST_DEV: if (cnt_q == 4'd8) begin
          if (addr_ok) begin
            oe_q    <= 1'b1;
            st_q    <= ST_ACK;
            blk_q   <= block_of(sh_q, BLK_BITS);
            after_q <= sh_q[0] ? ST_RDATA : ST_WORD;
          end else begin
            st_q <= ST_IDLE;
          end
        end
        ST_WORD: if (cnt_q == 4'd8) begin
          ptr_q   <= AW'({blk_q, sh_q});
          oe_q    <= 1'b1;
          st_q    <= ST_ACK;
          after_q <= ST_WDATA;
        end
        ST_WDATA: if (cnt_q == 4'd8) begin
          ptr_q   <= AW'(next_wr_ptr(11'(ptr_q)));
          oe_q    <= 1'b1;
          st_q    <= ST_ACK;
          after_q <= ST_WDATA;
        end
        ST_ACK: begin
          st_q  <= after_q;
          cnt_q <= '0;
          oe_q  <= 1'b0;
          if (after_q == ST_RDATA) begin
            sh_q  <= rdata_i;
            oe_q  <= !rdata_i[7];
            cnt_q <= 4'd1;
          end
        end
        ST_RDATA: begin
          if (cnt_q == 4'd8) begin
            oe_q <= 1'b0;
            st_q <= ST_RACK;
          end else begin
            sh_q  <= {sh_q[6:0], 1'b0};
            oe_q  <= !sh_q[6];
            cnt_q <= cnt_q + 4'd1;
          end
        end
        ST_RACK: begin
          if (mack_q) begin
            sh_q  <= rdata_i;
            oe_q  <= !rdata_i[7];
            cnt_q <= 4'd1;
            st_q  <= ST_RDATA;
          end else begin
            st_q <= ST_IDLE;
          end
        end
        default: ;
      endcase
    end
  end

  p_start_dev_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (st_q == ST_DEV));
  p_stop_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> (st_q == ST_IDLE && !oe_q));
  p_oe_scl_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_q != $past(oe_q)) |-> !scl_q_i);
  p_mismatch_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_done && st_q == ST_DEV && !addr_ok) |=> (st_q == ST_IDLE && !oe_q));
  p_data_ack_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wbyte_done |=> oe_q);
endmodule

// File: rtl/serial_eeprom_slave.sv
module serial_eeprom_slave #(
  parameter int BLK_BITS = 1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o,
  input  logic [2:0] addr_pins_i,
  input  logic       wp_i
);
  localparam int AW = 8 + BLK_BITS;

  logic scl_q, sda_q, start_ev, stop_ev, rise_ev, fall_ev;
  logic mem_we;
  logic [7:0] wdata, rdata;
  logic [AW-1:0] ptr;

  twi_line_mon u_mon (
    .clk_i(clk_i), .rst_ni(rst_ni), .scl_i(scl_i), .sda_i(sda_i),
    .scl_q_o(scl_q), .sda_q_o(sda_q), .start_o(start_ev), .stop_o(stop_ev),
    .rise_o(rise_ev), .fall_o(fall_ev)
  );

  twi_ee_ctrl #(.BLK_BITS(BLK_BITS), .AW(AW)) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .scl_q_i(scl_q), .sda_q_i(sda_q),
    .start_i(start_ev), .stop_i(stop_ev), .rise_i(rise_ev), .fall_i(fall_ev),
    .pins_i(addr_pins_i), .wp_i(wp_i), .rdata_i(rdata), .ptr_o(ptr),
    .we_o(mem_we), .wdata_o(wdata), .sda_oe_o(sda_oe_o)
  );

  twi_ee_array #(.AW(AW)) u_array (
    .clk_i(clk_i), .we_i(mem_we), .waddr_i(ptr), .wdata_i(wdata),
    .raddr_i(ptr), .rdata_o(rdata)
  );

  p_protect_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wp_i |-> !mem_we);
endmodule

// File: tb/serial_eeprom_slave_tb.sv
`timescale 1ns/1ps
module serial_eeprom_slave_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1, sda_m = 1'b1, wp = 1'b0;
  logic [2:0] pins = 3'b101;
  logic sda_oe, sda_w;
  int n_chk = 0, n_fail = 0, r2_viol = 0;
  bit done = 0;

  always #2 clk = ~clk;
  assign sda_w = sda_m & ~sda_oe;

  serial_eeprom_slave #(.BLK_BITS(1)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_w),
    .sda_oe_o(sda_oe), .addr_pins_i(pins), .wp_i(wp)
  );

  // reference model: memory image and pointer
  logic [7:0] mem_m [512];
  int ptr_m = 0;

  // R2 monitor, every clock
  logic prev_oe = 1'b0;
  always @(negedge clk) begin
    if (rst_n && scl && sda_oe !== prev_oe) r2_viol++;
    prev_oe <= sda_oe;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wt(input int n); repeat (n) @(negedge clk); endtask

  task automatic bus_start;
    sda_m = 1'b1; wt(4); scl = 1'b1; wt(4); sda_m = 1'b0; wt(4); scl = 1'b0; wt(4);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; wt(4); scl = 1'b1; wt(4); sda_m = 1'b1; wt(4);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wt(4); scl = 1'b1; wt(4); scl = 1'b0; wt(1);
    end
    sda_m = 1'b1; wt(4); scl = 1'b1; wt(2); ack = !sda_w; wt(2); scl = 1'b0; wt(2);
  endtask

  task automatic recv_byte(output logic [7:0] b, input logic mack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; wt(4); scl = 1'b1; wt(2); b[i] = sda_w; wt(2); scl = 1'b0; wt(1);
    end
    sda_m = !mack; wt(4); scl = 1'b1; wt(4); scl = 1'b0; wt(1);
  endtask

  function automatic logic [7:0] dev(input int addr, input bit rd);
    return 8'hA8 | 8'((addr >> 8) & 1) << 1 | 8'(rd);
  endfunction

  task automatic set_word(input int addr);
    logic a;
    bus_start;
    send_byte(dev(addr, 0), a); chk(a, "R4", "address ack (write)", a, 1);
    send_byte(8'(addr & 'hff), a); chk(a, "R5", "word address ack", a, 1);
    ptr_m = addr;
  endtask

  task automatic wr_bytes(input int addr, input logic [7:0] d [$]);
    logic a;
    set_word(addr);
    foreach (d[k]) begin
      send_byte(d[k], a);
      chk(a, wp ? "R7" : "R6", "data byte ack", a, 1);
      if (!wp) mem_m[ptr_m] = d[k];
      ptr_m = (ptr_m & 'h100) | ((ptr_m + 1) & 'hff);
    end
    bus_stop;
  endtask

  task automatic rd_cur(input int n, input string req);
    logic a;
    logic [7:0] b;
    bus_start;
    send_byte(dev(ptr_m, 1), a); chk(a, "R4", "address ack (read)", a, 1);
    for (int k = 0; k < n; k++) begin
      recv_byte(b, k < n - 1);
      chk(b == mem_m[ptr_m], req, "read byte", b, mem_m[ptr_m]);
      ptr_m = (ptr_m + 1) & 'h1ff;
    end
    bus_stop;
  endtask

  task automatic rd_rand(input int addr, input int n, input string req);
    set_word(addr);
    rd_cur(n, req);
  endtask

  initial begin
    logic a;
    logic [7:0] b;
    wt(5); rst_n = 1'b1; wt(3);
    chk(sda_oe == 1'b0, "R1", "reset drive", sda_oe, 0);

    // block 1 write then random read
    wr_bytes('h110, '{8'h5A, 8'hC3});
    rd_rand('h110, 2, "R5");

    // write runs past 0xFF and wraps inside block 0
    wr_bytes('h0FF, '{8'h11, 8'h22, 8'h33});
    rd_rand('h0FF, 1, "R6");
    rd_rand('h000, 2, "R6");

    // read from the last location wraps to 0
    wr_bytes('h1FF, '{8'h99});
    rd_rand('h1FF, 2, "R8");

    // current-address read continues at 0x001
    rd_cur(1, "R10");

    // protected write is acknowledged but ignored
    wp = 1'b1;
    wr_bytes('h110, '{8'h77});
    wp = 1'b0;
    rd_rand('h110, 1, "R7");

    // address mismatch on pin position x2
    bus_start;
    send_byte(8'hA0, a); chk(!a, "R3", "no ack on mismatch", a, 0);
    send_byte(8'h00, a); chk(!a, "R3", "silent after mismatch", a, 0);
    bus_stop;

    // master NACK then silence
    bus_start;
    send_byte(dev(0, 1), a); chk(a, "R4", "address ack", a, 1);
    recv_byte(b, 1'b0);
    chk(b == mem_m[ptr_m], "R9", "byte before nack", b, mem_m[ptr_m]);
    ptr_m = (ptr_m + 1) & 'h1ff;
    recv_byte(b, 1'b0);
    chk(b == 8'hFF, "R9", "released after nack", b, 8'hFF);
    bus_stop;

    // stop ends transfer; bytes without start are ignored
    bus_start;
    send_byte(dev(0, 0), a); chk(a, "R4", "address ack", a, 1);
    bus_stop;
    chk(sda_oe == 1'b0, "R1", "released after stop", sda_oe, 0);
    send_byte(dev(0, 0), a); chk(!a, "R1", "no ack without start", a, 0);

    chk(r2_viol == 0, "R2", "drive changes while SCL high", r2_viol, 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule